// File: doc/BRIEF.md
# Chip-select output port

This block drives a small bank of general-purpose output pins. Any of them can also serve as a chip select for a serial peripheral bus. A configuration register holds two bits per pin. One marks the pin as a chip select for the pad multiplexer. The other inverts the level that reaches the pin. Software changes the stored output bits through a separate write port. That port carries a set mask in its upper half and a clear mask in its lower half, so single pins can be raised or lowered in one write, with no read-modify-write.

The stored output bits can be read back on a status port, before inversion. The pin outputs are registered. They change on the same clock edge that stores a write to either register. After reset every stored bit is 1, the configuration is zero, and every pin is high: no pin is in chip-select mode and none is inverted.

Top module: `cs_out_port`

## Requirements
- R1: After reset, cfg_rdata_o is 0, cs_mode_o is 0, stat_o is all ones and pin_o is all ones.
- R2: A write with cfg_we_i loads cfg_wdata_i into the configuration register on that clock edge. cfg_rdata_o returns the value. Bits NP+n drive cs_mode_o[n], and bits n are the invert bits for pin n.
- R3: A write with sc_we_i and sc_wdata_i[NP+n]=1 makes stored bit n equal to 1 (stat_o[n]=1) after that edge.
- R4: A write with sc_we_i, sc_wdata_i[n]=1 and sc_wdata_i[NP+n]=0 makes stored bit n equal to 0 after that edge.
- R5: A stored bit whose set and clear bits are both 0 keeps its value, and so does every stored bit when sc_we_i is low.
- R6: When the set bit and the clear bit of the same pin are written as 1 together, the stored bit becomes 1.
- R7: Writing 0xFF00 to the set/clear port (with NP=8) drives all stored bits to 1, whatever their previous value.
- R8: pin_o[n] equals stat_o[n] XOR invert bit n at every cycle after reset. A write that changes either input changes the pin on the same clock edge.
- R9: stat_o reports the stored bits before inversion, so changing the invert bits leaves stat_o unchanged.
- R10: A set/clear write leaves the configuration register unchanged, and a configuration write leaves the stored bits unchanged. Both writes in the same cycle each take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 2*NP | Configuration data: upper half chip-select mode, lower half invert |
| sc_we_i | input | 1 | Set/clear port write strobe |
| sc_wdata_i | input | 2*NP | Upper half set mask, lower half clear mask |
| cfg_rdata_o | output | 2*NP | Configuration register readback |
| stat_o | output | NP | Stored output bits before inversion |
| cs_mode_o | output | NP | Per-pin chip-select mode select |
| pin_o | output | NP | Registered pin levels |

## Verification
Directed writes cover all-set (0xFF00), all-clear and overlapping set-and-clear masks. These show apart the priority of set over clear and a mask that is simply applied in full. Walking single-bit masks over a mixed stored pattern show that untouched pins hold their value and that no bit lane is swapped. Random mixes of configuration and set/clear writes, some in the same cycle, are compared against a bench model of stored bits and pin levels. This separates a pin that follows the new inversion at once from one that lags a cycle, and a status readback taken before inversion from one taken after it.

// File: rtl/cs_port_pkg.sv
package cs_port_pkg;
  localparam int unsigned DefPins = 8;
endpackage

// File: rtl/cs_cfg_reg.sv
module cs_cfg_reg #(
  parameter int unsigned NP = cs_port_pkg::DefPins,
  localparam int unsigned CW = 2 * NP
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] cfg_o,
  output logic [CW-1:0] cfg_nxt_o
);
  logic [CW-1:0] cfg_q;

  always_comb cfg_nxt_o = we_i ? wdata_i : cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_nxt_o;
  end

  assign cfg_o = cfg_q;

  // R2
  cfg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cfg_q == $past(wdata_i)));
  // R10
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_q));
endmodule

// File: rtl/cs_set_clr.sv
module cs_set_clr #(
  parameter int unsigned NP = cs_port_pkg::DefPins,
  localparam int unsigned CW = 2 * NP
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CW-1:0] wdata_i,
  output logic [NP-1:0] out_o,
  output logic [NP-1:0] out_nxt_o
);
  logic [NP-1:0] out_q;
  logic [NP-1:0] set_m, clr_m;

  assign set_m = we_i ? wdata_i[CW-1:NP] : '0;
  assign clr_m = we_i ? wdata_i[NP-1:0]  : '0;

  for (genvar i = 0; i < NP; i++) begin : g_bit
    // set wins over clear
    always_comb begin
      if (set_m[i])      out_nxt_o[i] = 1'b1;
      else if (clr_m[i]) out_nxt_o[i] = 1'b0;
      else               out_nxt_o[i] = out_q[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) out_q[i] <= 1'b1;
      else         out_q[i] <= out_nxt_o[i];
    end

    // R3
    set_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && wdata_i[NP+i]) |=> out_q[i]);
    // R4
    clr_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && wdata_i[i] && !wdata_i[NP+i]) |=> !out_q[i]);
    // R5
    hold_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!we_i || (!wdata_i[i] && !wdata_i[NP+i])) |=> $stable(out_q[i]));
  end

  assign out_o = out_q;
endmodule

// File: rtl/cs_pin_drv.sv
module cs_pin_drv #(
  parameter int unsigned NP = cs_port_pkg::DefPins
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NP-1:0] out_nxt_i,
  input  logic [NP-1:0] inv_nxt_i,
  output logic [NP-1:0] pin_o
);
  for (genvar i = 0; i < NP; i++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pin_o[i] <= 1'b1;
      else         pin_o[i] <= out_nxt_i[i] ^ inv_nxt_i[i];
    end
  end
endmodule

// File: rtl/cs_out_port.sv
module cs_out_port #(
  parameter int unsigned NP = cs_port_pkg::DefPins,
  localparam int unsigned CW = 2 * NP
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [CW-1:0] cfg_wdata_i,
  input  logic          sc_we_i,
  input  logic [CW-1:0] sc_wdata_i,
  output logic [CW-1:0] cfg_rdata_o,
  output logic [NP-1:0] stat_o,
  output logic [NP-1:0] cs_mode_o,
  output logic [NP-1:0] pin_o
);
  logic [CW-1:0] cfg_q, cfg_nxt;
  logic [NP-1:0] out_q, out_nxt;

  cs_cfg_reg #(.NP(NP)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
    .cfg_o(cfg_q), .cfg_nxt_o(cfg_nxt)
  );

  cs_set_clr #(.NP(NP)) u_sc (
    .clk_i, .rst_ni, .we_i(sc_we_i), .wdata_i(sc_wdata_i),
    .out_o(out_q), .out_nxt_o(out_nxt)
  );

  cs_pin_drv #(.NP(NP)) u_pin (
    .clk_i, .rst_ni, .out_nxt_i(out_nxt), .inv_nxt_i(cfg_nxt[NP-1:0]),
    .pin_o
  );

  assign cfg_rdata_o = cfg_q;
  assign stat_o      = out_q;
  assign cs_mode_o   = cfg_q[CW-1:NP];

  // R8
  pin_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_o == (out_q ^ cfg_q[NP-1:0]));
  // R10
  sc_keeps_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_we_i && !cfg_we_i) |=> $stable(cfg_q));
  // R6
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_we_i && ((sc_wdata_i[CW-1:NP] & sc_wdata_i[NP-1:0]) != '0))
    |=> ((out_q & $past(sc_wdata_i[CW-1:NP] & sc_wdata_i[NP-1:0]))
         == $past(sc_wdata_i[CW-1:NP] & sc_wdata_i[NP-1:0])));
endmodule

// File: tb/sim_cs_out_port.sv
module sim_cs_out_port;
  localparam int NP = 8;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, sc_we = 1'b0;
  logic [CW-1:0] cfg_wd = '0, sc_wd = '0;
  logic [CW-1:0] cfg_rd;
  logic [NP-1:0] stat, csm, pin;

  int checks = 0, fails = 0;
  logic [CW-1:0] m_cfg;
  logic [NP-1:0] m_out;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cs_out_port #(.NP(NP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd),
    .sc_we_i(sc_we), .sc_wdata_i(sc_wd), .cfg_rdata_o(cfg_rd),
    .stat_o(stat), .cs_mode_o(csm), .pin_o(pin)
  );

  function automatic logic [NP-1:0] apply_sc(logic [NP-1:0] o, logic [CW-1:0] w);
    return (o & ~w[NP-1:0]) | w[CW-1:NP];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " cfg"}, 32'(cfg_rd), 32'(m_cfg));
    chk({req, " csmode"}, 32'(csm), 32'(m_cfg[CW-1:NP]));
    chk({req, " stat"}, 32'(stat), 32'(m_out));
    chk({req, " pin"}, 32'(pin), 32'(m_out ^ m_cfg[NP-1:0]));
  endtask

  task automatic wr(logic cw, logic [CW-1:0] cd, logic sw, logic [CW-1:0] sd, string req);
    cfg_we = cw; cfg_wd = cd; sc_we = sw; sc_wd = sd;
    @(negedge clk);
    cfg_we = 1'b0; sc_we = 1'b0;
    if (cw) m_cfg = cd;
    if (sw) m_out = apply_sc(m_out, sd);
    chk_all(req);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_cfg = '0; m_out = '1;
    repeat (3) @(negedge clk);
    chk_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after release");

    wr(0, '0, 1, 16'h00FF, "R4 clear all");
    wr(0, '0, 1, 16'hFF00, "R7 set all");
    wr(0, '0, 1, 16'h00A5, "R4 clear mask");
    wr(0, '0, 1, 16'h0000, "R5 zero mask");
    wr(0, '0, 1, 16'h0F0F, "R6 set and clear");
    chk("R6 stat", 32'(stat[3:0]), 32'hF);
    wr(0, '0, 1, 16'h00FF, "R4 clear all 2");
    wr(0, '0, 1, 16'hFF00, "R7 from zero");
    chk("R7 stat", 32'(stat), 32'hFF);
    for (int i = 0; i < NP; i++) begin
      wr(0, '0, 1, 16'(1 << i), "R4 walk clear");
      wr(0, '0, 1, 16'(1 << (i + NP)), "R3 walk set");
    end
    wr(0, '0, 1, 16'h0055, "R4 pattern");
    wr(1, 16'h3C0F, 0, '0, "R2 cfg write");
    chk("R9 stat unaffected by invert", 32'(stat), 32'hAA);
    chk("R8 pin inverted", 32'(pin), 32'hA5);
    wr(1, 16'hC3F0, 1, 16'h0100, "R10 both writes");
    @(negedge clk);
    chk_all("R5 idle hold");

    for (int k = 0; k < 400; k++) begin
      logic cw, sw;
      logic [CW-1:0] cd, sd;
      cw = ($urandom % 4) == 0;
      sw = ($urandom % 3) != 0;
      cd = 16'($urandom);
      sd = 16'($urandom);
      if (($urandom % 8) == 0) sd = 16'hFF00;
      wr(cw, cd, sw, sd, "R8 random");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule